// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Sequencer

This block moves data for two DMA channels, each started by an active-low external request pin. It works in cycle-steal fashion. Each accepted request moves exactly one transfer unit. A unit is a read from the channel's source address, followed by a write of that data to the channel's destination address. After each unit the sequencer gives the bus back and waits for a minimum number of CPU bus cycles before it steals the bus again. When both channels are waiting, they take turns.

Software loads a channel through a load strobe that carries a source address, a destination address, a 16-bit unit count and a sensing mode. The load enables the channel when the count is nonzero. Each unit advances both addresses by the unit size and lowers the count. The unit that brings the count to zero clears the enable and sets the channel's done flag.

During each unit the channel's acknowledge output is high. During the channel's final unit its last-unit output is also high. The bus side is a request/grant/done handshake.

The sequencer has five states:
- `ST_IDLE`: waits for an enabled channel with a pending request. Taking that request is the acceptance.
- `ST_LAUNCH`: counts the start latency while the bus request is held. It moves to `ST_READ` once the latency has elapsed and the grant is present.
- `ST_READ`: runs the source read. It moves to `ST_WRITE` on done.
- `ST_WRITE`: runs the destination write. It moves to `ST_YIELD` on done.
- `ST_YIELD`: releases the bus and counts CPU bus-cycle pulses. It returns to `ST_IDLE` after the minimum is reached.

Top module: `csdma_seq`

## Requirements
- R1: The first read cycle of a unit (the acknowledge going high) starts no earlier than 3 clock cycles after the request is accepted. With the grant already present, it starts exactly 3 cycles after acceptance. Sampled at the ports with the grant present, the acknowledge is first high after the 5th rising edge that follows a low level on the pin (low-level mode), or after the 6th (falling-edge mode).
- R2: Each accepted request moves exactly one unit. A channel is not accepted again until its unit's write has completed.
- R3: After each unit, `bus_req` stays low and no acknowledge is raised until at least 2 pulses have been seen on `cpu_cycle`.
- R4: When another channel is pending, it is served before the channel just served runs again. After reset, channel 0 wins a tie.
- R5: `ld_edge=0` selects low-level sensing: the pin is a request while it is low, and it is resampled only when the sequencer is idle. `ld_edge=1` selects falling-edge sensing: one high-to-low transition latches one request, so a pin held low yields one unit.
- R6: A unit is a read (`bus_we=0`) at the source address, followed by a write (`bus_we=1`) to the destination address carrying the data that was read. `bus_req` is high during both.
- R7: `chan_ack[i]` is high only while channel i's read or write runs, and at most one bit is set. `chan_last[i]` is high only within that window, and only during the channel's final unit.
- R8: After each unit the addresses grow by `UNIT_BYTES` and the count drops by one. When the count reaches zero, `ch_en[i]` clears and `ch_done[i]` sets.
- R9: After reset, both channels are disabled, no request is pending, `bus_req` is low and all acknowledges are low.
- R10: A channel whose enable is clear ignores its request pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pin_n | input | NCH | Active-low external request per channel |
| ld_stb | input | NCH | Per-channel load strobe |
| ld_src | input | ADDR_W | Source address to load |
| ld_dst | input | ADDR_W | Destination address to load |
| ld_cnt | input | CNT_W | Unit count to load |
| ld_edge | input | 1 | Sense mode to load: 1 falling edge, 0 low level |
| cpu_cycle | input | 1 | One pulse per completed CPU bus cycle |
| bus_gnt | input | 1 | Bus grant |
| bus_done | input | 1 | Current read or write completes this cycle |
| bus_rdata | input | DATA_W | Read data |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| chan_ack | output | NCH | Per-channel acknowledge |
| chan_last | output | NCH | Per-channel final-unit strobe |
| ch_en | output | NCH | Channel enable |
| ch_done | output | NCH | Channel count exhausted |

## Verification
The hardest case to reach is the turn-taking. It needs one channel to become pending while the other channel's unit and yield are still in progress, and the served channel must still be requesting when the sequencer returns to idle. The stimulus gets there in two steps.

First, it holds a level-sensed channel 0 low. In the same cycle, it gives an edge-sensed channel 1 a falling edge. The level channel is accepted a cycle earlier than the edge channel, so channel 0 is served first while channel 1 waits.

Second, because channel 0 is still requesting after its unit, the next idle cycle must pick channel 1 over it. The scoreboard holds the order ch0, ch1, ch0, ch0. A separate phase stops the CPU pulses, which makes the yield wait observable at the ports.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_READ,
        ST_WRITE,
        ST_YIELD
    } seq_state_e;
endpackage

// File: rtl/csdma_sense.sv
module csdma_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic enable,
    input  logic take,
    output logic pending
);
    logic samp_q;
    logic prev_q;
    logic latch_q;
    logic fall;

    assign fall = prev_q & ~samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q  <= 1'b1;
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            samp_q <= pin_n;
            prev_q <= samp_q;
            if (!enable || !edge_mode) begin
                latch_q <= 1'b0;
            end else if (fall) begin
                latch_q <= 1'b1;
            end else if (take) begin
                latch_q <= 1'b0;
            end
        end
    end

    assign pending = enable & (edge_mode ? latch_q : ~samp_q);
endmodule

// File: rtl/csdma_chan.sv
module csdma_chan #(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int UNIT_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_src,
    input  logic [ADDR_W-1:0] load_dst,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              load_edge,
    input  logic              step,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic              final_unit,
    output logic              en,
    output logic              done,
    output logic              edge_mode
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(UNIT_BYTES);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src       <= '0;
            dst       <= '0;
            cnt_q     <= '0;
            en        <= 1'b0;
            done      <= 1'b0;
            edge_mode <= 1'b0;
        end else if (load) begin
            src       <= load_src;
            dst       <= load_dst;
            cnt_q     <= load_cnt;
            en        <= (load_cnt != '0);
            done      <= 1'b0;
            edge_mode <= load_edge;
        end else if (step) begin
            src   <= src + STRIDE;
            dst   <= dst + STRIDE;
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
                en   <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign final_unit = (cnt_q == ONE);
endmodule

// File: rtl/csdma_arb.sv
module csdma_arb #(
    parameter int NCH = 2,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   pending,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        int idx;
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= NCH; k++) begin
            idx = (int'(last) + k) % NCH;
            if (!any && pending[idx]) begin
                any  = 1'b1;
                pick = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/csdma_seq.sv
module csdma_seq
    import csdma_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int UNIT_BYTES = 2,
    parameter int START_LAT  = 3,
    parameter int MIN_CPU    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_pin_n,
    input  logic [NCH-1:0]    ld_stb,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              ld_edge,
    input  logic              cpu_cycle,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [NCH-1:0]    chan_ack,
    output logic [NCH-1:0]    chan_last,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_done
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int LAT_W = $clog2(START_LAT + 1);
    localparam int GAP_W = $clog2(MIN_CPU + 1);

    seq_state_e         state;
    logic [IDX_W-1:0]   cur_ch;
    logic [IDX_W-1:0]   last_ch;
    logic [LAT_W-1:0]   lat_cnt;
    logic [GAP_W-1:0]   gap_cnt;
    logic [DATA_W-1:0]  data_q;

    logic [NCH-1:0]     pending;
    logic [NCH-1:0]     take;
    logic [NCH-1:0]     step;
    logic [NCH-1:0]     fin;
    logic [NCH-1:0]     edge_sel;
    logic [ADDR_W-1:0]  src_a [NCH];
    logic [ADDR_W-1:0]  dst_a [NCH];
    logic               arb_any;
    logic [IDX_W-1:0]   arb_pick;
    logic               accept;
    logic               in_unit;

    assign accept = (state == ST_IDLE) && arb_any;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign take[g] = accept && (arb_pick == IDX_W'(g));
        assign step[g] = (state == ST_WRITE) && bus_done && (cur_ch == IDX_W'(g));

        csdma_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (req_pin_n[g]),
            .edge_mode (edge_sel[g]),
            .enable    (ch_en[g]),
            .take      (take[g]),
            .pending   (pending[g])
        );

        csdma_chan #(
            .ADDR_W     (ADDR_W),
            .CNT_W      (CNT_W),
            .UNIT_BYTES (UNIT_BYTES)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (ld_stb[g]),
            .load_src   (ld_src),
            .load_dst   (ld_dst),
            .load_cnt   (ld_cnt),
            .load_edge  (ld_edge),
            .step       (step[g]),
            .src        (src_a[g]),
            .dst        (dst_a[g]),
            .final_unit (fin[g]),
            .en         (ch_en[g]),
            .done       (ch_done[g]),
            .edge_mode  (edge_sel[g])
        );
    end

    csdma_arb #(.NCH(NCH)) u_arb (
        .pending (pending),
        .last    (last_ch),
        .any     (arb_any),
        .pick    (arb_pick)
    );

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_ch  <= '0;
            last_ch <= IDX_W'(NCH - 1);
            lat_cnt <= '0;
            gap_cnt <= '0;
            data_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        cur_ch  <= arb_pick;
                        last_ch <= arb_pick;
                        lat_cnt <= '0;
                        state   <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    if (lat_cnt != LAT_W'(START_LAT - 1)) begin
                        lat_cnt <= lat_cnt + 1'b1;
                    end else if (bus_gnt) begin
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (bus_done) begin
                        data_q <= bus_rdata;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (bus_done) begin
                        gap_cnt <= '0;
                        state   <= ST_YIELD;
                    end
                end
                ST_YIELD: begin
                    if (gap_cnt == GAP_W'(MIN_CPU)) begin
                        state <= ST_IDLE;
                    end else if (cpu_cycle) begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_unit = (state == ST_READ) || (state == ST_WRITE);

    // Outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = src_a[cur_ch];
        bus_wdata = data_q;
        chan_ack  = '0;
        chan_last = '0;
        unique case (state)
            ST_LAUNCH: bus_req = 1'b1;
            ST_READ:   bus_req = 1'b1;
            ST_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst_a[cur_ch];
            end
            default: ;
        endcase
        if (in_unit) begin
            chan_ack[cur_ch]  = 1'b1;
            chan_last[cur_ch] = fin[cur_ch];
        end
    end
endmodule

// File: rtl/csdma_seq_chk.sv
module csdma_seq_chk #(
    parameter int NCH       = 2,
    parameter int START_LAT = 3,
    parameter int MIN_CPU   = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           accept,
    input logic           cpu_cycle,
    input logic           bus_req,
    input logic           bus_we,
    input logic [NCH-1:0] chan_ack,
    input logic [NCH-1:0] chan_last
);
    logic [7:0] since_acc;
    logic [7:0] cpu_seen;
    logic       had_unit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc <= 8'hFF;
            cpu_seen  <= '0;
            had_unit  <= 1'b0;
        end else begin
            if (accept) since_acc <= '0;
            else if (since_acc != 8'hFF) since_acc <= since_acc + 1'b1;
            if (|chan_ack) begin
                cpu_seen <= '0;
                had_unit <= 1'b1;
            end else if (cpu_cycle && cpu_seen != 8'hFF) begin
                cpu_seen <= cpu_seen + 1'b1;
            end
        end
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chan_ack) |-> (since_acc >= 8'(START_LAT)));                  // R1

    AST_CPU_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|chan_ack) && had_unit) |-> (cpu_seen >= 8'(MIN_CPU)));       // R3

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));                                                 // R7

    AST_LAST_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_last & ~chan_ack) == '0);                                      // R7

    AST_UNIT_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chan_ack) |-> !bus_we);                                       // R6

    AST_ACK_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_ack) |-> bus_req);                                            // R6
endmodule

bind csdma_seq csdma_seq_chk #(
    .NCH       (NCH),
    .START_LAT (START_LAT),
    .MIN_CPU   (MIN_CPU)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cpu_cycle (cpu_cycle),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .chan_ack  (chan_ack),
    .chan_last (chan_last)
);

// File: tb/csdma_seq_bench.sv
`timescale 1ns/1ps
module csdma_seq_bench;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_pin_n = 2'b11;
    logic [1:0]  ld_stb = 2'b00;
    logic [15:0] ld_src = '0;
    logic [15:0] ld_dst = '0;
    logic [15:0] ld_cnt = '0;
    logic        ld_edge = 1'b0;
    logic        cpu_cycle = 1'b0;
    logic        bus_gnt;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr, bus_wdata;
    logic [1:0]  chan_ack, chan_last, ch_en, ch_done;

    bit cpu_on = 1'b1;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int          ch;
        logic [15:0] src;
        logic [15:0] dst;
        bit          last;
    } unit_t;
    unit_t sb[$];

    always #2 clk = ~clk;

    function automatic logic [15:0] mem_model(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    assign bus_gnt   = bus_req;
    assign bus_rdata = mem_model(bus_addr);

    csdma_seq u_csdma_seq (
        .clk(clk), .rst_n(rst_n), .req_pin_n(req_pin_n), .ld_stb(ld_stb),
        .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_edge(ld_edge),
        .cpu_cycle(cpu_cycle), .bus_gnt(bus_gnt), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .chan_ack(chan_ack),
        .chan_last(chan_last), .ch_en(ch_en), .ch_done(ch_done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic push(input int ch, input logic [15:0] s, input logic [15:0] d, input bit l);
        unit_t u;
        u.ch = ch; u.src = s; u.dst = d; u.last = l;
        sb.push_back(u);
    endtask

    // Bus responder and scoreboard monitor: decides at the falling edge
    // whether the running phase completes at the next rising edge.
    always @(negedge clk) begin
        bit nd;
        int ach;
        cpu_cycle <= cpu_on ? ~cpu_cycle : 1'b0;
        nd  = (|chan_ack) && !bus_done;
        ach = chan_ack[1] ? 1 : 0;
        if (nd && rst_n) begin
            if (sb.size() == 0) begin
                check(0, "R2 unit with nothing expected", ach, -1);
            end else if (!bus_we) begin
                check(ach == sb[0].ch, "R4 read channel order", ach, sb[0].ch);
                check(bus_addr == sb[0].src, "R6 read address", bus_addr, sb[0].src);
            end else begin
                unit_t u;
                u = sb.pop_front();
                check(ach == u.ch, "R4 write channel order", ach, u.ch);
                check(bus_addr == u.dst, "R6 write address", bus_addr, u.dst);
                check(bus_wdata == mem_model(u.src), "R6 write data", bus_wdata, mem_model(u.src));
                check(chan_last[ach] == u.last, "R7 last-unit strobe", chan_last[ach], u.last);
            end
        end
        bus_done = nd;
    end

    task automatic load(input int ch, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] c, input bit e);
        @(negedge clk);
        ld_stb = '0; ld_stb[ch] = 1'b1;
        ld_src = s; ld_dst = d; ld_cnt = c; ld_edge = e;
        @(negedge clk);
        ld_stb = '0;
    endtask

    task automatic measure(input int ch, input int exp_n, input string what);
        int n = 0;
        while (!chan_ack[ch] && n < 60) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check(n == exp_n, what, n, exp_n);
    endtask

    task automatic idle_check(input int cycles, input string what);
        bit quiet = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bus_req || (|chan_ack)) quiet = 1'b0;
        end
        check(quiet, what, quiet, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(bus_req == 1'b0, "R9 bus_req after reset", bus_req, 0);
        check(chan_ack == 2'b00, "R9 ack after reset", chan_ack, 0);
        check(ch_en == 2'b00, "R9 channels disabled", ch_en, 0);
        check(ch_done == 2'b00, "R9 done clear", ch_done, 0);
        // R10: disabled channel ignores its pin
        req_pin_n = 2'b00;
        idle_check(20, "R10 pins ignored while disabled");
        req_pin_n = 2'b11;

        // R4 tie after reset: channel 0 first, both falling-edge
        load(0, 16'h0100, 16'h0200, 16'd1, 1'b1);
        load(1, 16'h0300, 16'h0400, 16'd1, 1'b1);
        repeat (4) @(negedge clk);
        push(0, 16'h0100, 16'h0200, 1'b1);
        push(1, 16'h0300, 16'h0400, 1'b1);
        req_pin_n = 2'b00;
        repeat (50) @(negedge clk);
        req_pin_n = 2'b11;
        check(sb.size() == 0, "R4 tie units done", sb.size(), 0);
        check(ch_done == 2'b11, "R8 done flags after count 1", ch_done, 3);
        check(ch_en == 2'b00, "R8 enables cleared", ch_en, 0);

        // R1/R5 level-mode latency on channel 0
        load(0, 16'h1000, 16'h2000, 16'd3, 1'b0);
        load(1, 16'h3000, 16'h4000, 16'd2, 1'b1);
        repeat (4) @(negedge clk);
        push(0, 16'h1000, 16'h2000, 1'b0);
        req_pin_n[0] = 1'b0;
        measure(0, 5, "R1 R5 level-mode start latency");
        req_pin_n[0] = 1'b1;
        repeat (30) @(negedge clk);
        check(sb.size() == 0, "R2 one unit per level request", sb.size(), 0);

        // R1/R5 edge-mode latency, and a held-low pin yields one unit
        push(1, 16'h3000, 16'h4000, 1'b0);
        req_pin_n[1] = 1'b0;
        measure(1, 6, "R1 R5 edge-mode start latency");
        repeat (40) @(negedge clk);
        check(sb.size() == 0, "R5 one unit per falling edge", sb.size(), 0);
        check(ch_en[1] == 1'b1, "R8 channel 1 still enabled", ch_en[1], 1);
        req_pin_n[1] = 1'b1;
        repeat (5) @(negedge clk);

        // R3: no CPU cycles, so the sequencer must hold the bus released
        cpu_on = 1'b0;
        push(0, 16'h1002, 16'h2002, 1'b0);
        req_pin_n[0] = 1'b0;
        while (!chan_ack[0]) @(negedge clk);
        while (chan_ack[0]) @(negedge clk);
        push(0, 16'h1004, 16'h2004, 1'b1);
        idle_check(25, "R3 bus held released without CPU cycles");
        cpu_on = 1'b1;
        repeat (40) @(negedge clk);
        check(sb.size() == 0, "R3 unit resumes after CPU cycles", sb.size(), 0);
        check(ch_en[0] == 1'b0, "R8 enable cleared at count zero", ch_en[0], 0);
        check(ch_done[0] == 1'b1, "R8 done set at count zero", ch_done[0], 1);
        idle_check(30, "R10 finished channel ignores low pin");
        req_pin_n[0] = 1'b1;

        // R4 turn-taking: ch0 level held low, ch1 edge arrives meanwhile
        load(0, 16'h5000, 16'h6000, 16'd3, 1'b0);
        repeat (4) @(negedge clk);
        push(0, 16'h5000, 16'h6000, 1'b0);
        push(1, 16'h3002, 16'h4002, 1'b1);
        push(0, 16'h5002, 16'h6002, 1'b0);
        push(0, 16'h5004, 16'h6004, 1'b1);
        req_pin_n = 2'b00;
        repeat (90) @(negedge clk);
        req_pin_n = 2'b11;
        check(sb.size() == 0, "R4 alternation sequence complete", sb.size(), 0);
        check(ch_done == 2'b11, "R8 both done", ch_done, 3);
        check(ch_en == 2'b00, "R8 both disabled", ch_en, 0);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R2 no leftover units", sb.size(), 0);
        summary();
    end
endmodule